// File: doc/BRIEF.md
# Programmable Qualified Event Counter

This block is one performance-monitoring counter for a shared-cache and memory-request fabric. Software programs a control register with an event code, a unit mask, a count threshold, an edge flag, an invert flag and an enable bit. In every clock cycle the counter picks one event source out of a small bank: snoop responses, cache lookups on several lanes, request-tracker allocations and occupancy levels. It then works out how many selected events happened in that cycle and decides, through the qualifiers, how much to add to a 48-bit count.

Software reaches the block through a two-register port. Address 0 is the control register and address 1 is the count. The count can be preloaded and read back at any time. Occupancy sources add the number of pending requests in every cycle, so the count is the number of cycles weighted by occupancy. The counter wraps silently. It raises no interrupt and feeds no other counter.

Control register layout (address 0): bits [7:0] event code, bits [15:8] unit mask, bits [23:16] threshold, bit 24 edge flag, bit 25 invert flag, bit 26 enable. All other bits read as zero.

Top module: `perf_evt_counter`

## Requirements
- R1: After reset the count is 0 and the control register is 0. A write to address 0 reads back as the low 27 written bits, with the upper bits zero.
- R2: With threshold 0 and the edge flag clear, the count advances by the raw number of selected events in each enabled cycle.
- R3: With a nonzero threshold, the count advances by exactly 1 in each cycle where the per-cycle event number is at least the threshold, and by 0 in all other cycles.
- R4: With a nonzero threshold and the invert flag set, the count advances by 1 in each cycle where the per-cycle event number is below the threshold. With threshold 0, the invert flag has no effect.
- R5: With the edge flag set, the count advances by 1 only in a cycle where the qualified condition is true and was false in the previous enabled cycle. With threshold 0, the condition is "event number nonzero".
- R6: A write to address 1 loads the count and takes priority over an increment in the same cycle. Address 1 reads the count.
- R7: While the enable bit (bit 26) is clear, the count holds its value.
- R8: Code 0x22 adds the number of asserted snoop-response inputs whose unit-mask bit is set. Input bit k pairs with mask bit k: 0 miss, 1 invalidate clean, 2 hit clean, 3 hit modified, 4 invalidate modified. Mask bits 5 to 7 contribute nothing.
- R9: Code 0x34 counts the valid lookup lanes whose state matches a mask bit (state 0=M→bit0, 1=E→bit1, 2=S→bit2, 3=I→bit3). If any of mask bits 4 to 7 is set, the lane's one-hot request type (bit0 core read→bit4, bit1 core write→bit5, bit2 external snoop→bit6, bit3 any request→bit7) must also match. A mask with filter bits only counts nothing.
- R10: Codes 0x80 and 0x83 with mask bit 0 set add the tracker and coherency pending counts, respectively, in each cycle.
- R11: Code 0x81 counts tracker allocations: mask 0x01 counts all kinds, 0x20 counts writes and evictions, 0x80 counts evictions (kind 0 read, 1 write, 2 eviction). Code 0x84 with mask 0x01 counts coherency allocations.
- R12: An event code outside {0x22, 0x34, 0x80, 0x81, 0x83, 0x84}, or a mask that selects no source, adds nothing.
- R13: The count is 48 bits wide and wraps modulo 2^48.
- R14: A write to address 0 clears the stored previous condition used for edge detection, so a condition that stays true counts again after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 count |
| reg_wdata_i | input | 48 | Register write data |
| reg_rdata_o | output | 48 | Read data of the addressed register |
| snoop_resp_i | input | 5 | Snoop response types seen this cycle |
| lk_vld_i | input | 2 | Cache lookup valid per lane |
| lk_state_i | input | 4 | Line state per lane, 2 bits per lane |
| lk_req_i | input | 8 | One-hot request type per lane, 4 bits per lane |
| trk_pend_i | input | 6 | Requests pending in the request tracker |
| coh_pend_i | input | 6 | Requests pending in the coherency tracker |
| trk_alloc_i | input | 1 | New request-tracker allocation this cycle |
| trk_kind_i | input | 2 | Kind of that allocation |
| coh_alloc_i | input | 1 | New coherency-tracker allocation this cycle |

## Verification
A fault in the selection or qualifier logic shows up as a wrong count value. That value can be read on the cycle after the first stimulus cycle that exposes the fault. A stuck edge-history bit is different: a continuous condition is counted either on every cycle or never again. The bench therefore holds a condition across several cycles and also across a control write. A wrong priority between a preload and an increment leaves the preload value offset by one cycle's increment, and this is visible right after the write.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int SNP_TYPES = 5;

  localparam logic [7:0] CODE_SNOOP    = 8'h22;
  localparam logic [7:0] CODE_LOOKUP   = 8'h34;
  localparam logic [7:0] CODE_TRK_OCC  = 8'h80;
  localparam logic [7:0] CODE_TRK_REQ  = 8'h81;
  localparam logic [7:0] CODE_COH_OCC  = 8'h83;
  localparam logic [7:0] CODE_COH_REQ  = 8'h84;

  localparam logic [1:0] KIND_RD = 2'd0;
  localparam logic [1:0] KIND_WR = 2'd1;
  localparam logic [1:0] KIND_EV = 2'd2;

  typedef struct packed {
    logic       en;
    logic       inv;
    logic       edge_en;
    logic [7:0] cmask;
    logic [7:0] umask;
    logic [7:0] code;
  } pec_ctrl_t;

  localparam int CTRL_W = $bits(pec_ctrl_t);
endpackage

// File: rtl/pec_evt_select.sv
module pec_evt_select
  import pec_pkg::*;
#(
  parameter int LK_LANES = 2,
  parameter int OCC_W    = 6,
  parameter int EV_W     = 8
) (
  input  logic [7:0]            code_i,
  input  logic [7:0]            umask_i,
  input  logic [SNP_TYPES-1:0]  snoop_resp_i,
  input  logic [LK_LANES-1:0]   lk_vld_i,
  input  logic [2*LK_LANES-1:0] lk_state_i,
  input  logic [4*LK_LANES-1:0] lk_req_i,
  input  logic [OCC_W-1:0]      trk_pend_i,
  input  logic [OCC_W-1:0]      coh_pend_i,
  input  logic                  trk_alloc_i,
  input  logic [1:0]            trk_kind_i,
  input  logic                  coh_alloc_i,
  output logic [EV_W-1:0]       ev_cnt_o
);
  logic [LK_LANES-1:0] lk_hit;
  logic [3:0]          filt;

  assign filt = umask_i[7:4];

  for (genvar g = 0; g < LK_LANES; g++) begin : g_lane
    logic [1:0] st;
    logic [3:0] rq;
    assign st = lk_state_i[2*g +: 2];
    assign rq = lk_req_i[4*g +: 4];
    // state bit must match; filters narrow only when present
    assign lk_hit[g] = lk_vld_i[g] && umask_i[st] &&
                       ((filt == 4'd0) || (|(filt & rq)));
  end

  logic [EV_W-1:0] snp_sum;
  logic [EV_W-1:0] lk_sum;
  logic            trk_req_hit;

  always_comb begin
    snp_sum = '0;
    for (int i = 0; i < SNP_TYPES; i++)
      snp_sum = snp_sum + EV_W'(snoop_resp_i[i] & umask_i[i]);
  end

  always_comb begin
    lk_sum = '0;
    for (int i = 0; i < LK_LANES; i++)
      lk_sum = lk_sum + EV_W'(lk_hit[i]);
  end

  assign trk_req_hit = trk_alloc_i &&
      (umask_i[0] ||
       (umask_i[5] && (trk_kind_i == KIND_WR || trk_kind_i == KIND_EV)) ||
       (umask_i[7] && trk_kind_i == KIND_EV));

  always_comb begin
    unique case (code_i)
      CODE_SNOOP:   ev_cnt_o = snp_sum;
      CODE_LOOKUP:  ev_cnt_o = lk_sum;
      CODE_TRK_OCC: ev_cnt_o = umask_i[0] ? EV_W'(trk_pend_i) : '0;
      CODE_TRK_REQ: ev_cnt_o = EV_W'(trk_req_hit);
      CODE_COH_OCC: ev_cnt_o = umask_i[0] ? EV_W'(coh_pend_i) : '0;
      CODE_COH_REQ: ev_cnt_o = EV_W'(coh_alloc_i && umask_i[0]);
      default:      ev_cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/pec_qualify.sv
module pec_qualify #(
  parameter int EV_W = 8,
  parameter int CM_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [CM_W-1:0] cmask_i,
  input  logic            inv_i,
  input  logic            edge_i,
  input  logic [EV_W-1:0] ev_cnt_i,
  output logic [EV_W-1:0] inc_o,
  output logic            fire_o
);
  localparam int CMP_W = (EV_W > CM_W) ? EV_W : CM_W;

  logic [CMP_W-1:0] ev_x, cm_x;
  logic             thr_on, cond, prev_q;

  assign ev_x   = CMP_W'(ev_cnt_i);
  assign cm_x   = CMP_W'(cmask_i);
  assign thr_on = (cmask_i != '0);

  always_comb begin
    if (thr_on) cond = inv_i ? (ev_x < cm_x) : (ev_x >= cm_x);
    else        cond = (ev_cnt_i != '0);
  end

  always_comb begin
    if (edge_i)      inc_o = EV_W'(cond && !prev_q);
    else if (thr_on) inc_o = EV_W'(cond);
    else             inc_o = ev_cnt_i;
  end

  assign fire_o = (inc_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= 1'b0;
    else if (clr_i) prev_q <= 1'b0;
    else if (en_i)  prev_q <= cond;
  end
endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 48,
  parameter int EV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             en_i,
  input  logic [EV_W-1:0]  inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (ld_i)  cnt_o <= ld_val_i;
    else if (en_i)  cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter
  import pec_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int LK_LANES = 2,
  parameter int OCC_W    = 6,
  parameter int EV_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic                  reg_addr_i,
  input  logic [CNT_W-1:0]      reg_wdata_i,
  output logic [CNT_W-1:0]      reg_rdata_o,
  input  logic [SNP_TYPES-1:0]  snoop_resp_i,
  input  logic [LK_LANES-1:0]   lk_vld_i,
  input  logic [2*LK_LANES-1:0] lk_state_i,
  input  logic [4*LK_LANES-1:0] lk_req_i,
  input  logic [OCC_W-1:0]      trk_pend_i,
  input  logic [OCC_W-1:0]      coh_pend_i,
  input  logic                  trk_alloc_i,
  input  logic [1:0]            trk_kind_i,
  input  logic                  coh_alloc_i
);
  pec_ctrl_t        ctrl_q;
  logic             ctrl_wr, cnt_wr, fire;
  logic [EV_W-1:0]  ev_cnt, inc;
  logic [CNT_W-1:0] cnt;

  assign ctrl_wr = reg_we_i && !reg_addr_i;
  assign cnt_wr  = reg_we_i &&  reg_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= pec_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  pec_evt_select #(.LK_LANES(LK_LANES), .OCC_W(OCC_W), .EV_W(EV_W)) u_sel (
    .code_i       (ctrl_q.code),
    .umask_i      (ctrl_q.umask),
    .snoop_resp_i (snoop_resp_i),
    .lk_vld_i     (lk_vld_i),
    .lk_state_i   (lk_state_i),
    .lk_req_i     (lk_req_i),
    .trk_pend_i   (trk_pend_i),
    .coh_pend_i   (coh_pend_i),
    .trk_alloc_i  (trk_alloc_i),
    .trk_kind_i   (trk_kind_i),
    .coh_alloc_i  (coh_alloc_i),
    .ev_cnt_o     (ev_cnt)
  );

  pec_qualify #(.EV_W(EV_W), .CM_W(8)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ctrl_wr),
    .en_i     (ctrl_q.en),
    .cmask_i  (ctrl_q.cmask),
    .inv_i    (ctrl_q.inv),
    .edge_i   (ctrl_q.edge_en),
    .ev_cnt_i (ev_cnt),
    .inc_o    (inc),
    .fire_o   (fire)
  );

  pec_accum #(.CNT_W(CNT_W), .EV_W(EV_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_wr),
    .ld_val_i (reg_wdata_i),
    .en_i     (ctrl_q.en),
    .inc_i    (inc),
    .cnt_o    (cnt)
  );

  assign reg_rdata_o = reg_addr_i ? cnt : CNT_W'(ctrl_q);
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             en,
  input logic             edge_en,
  input logic [7:0]       cmask,
  input logic [7:0]       code,
  input logic             fire
);
  logic code_ok;
  assign code_ok = (code == 8'h22) || (code == 8'h34) || (code == 8'h80) ||
                   (code == 8'h81) || (code == 8'h83) || (code == 8'h84);

  assert_hold_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt));

  assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt == $past(wdata)));

  assert_unit_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cnt_wr && (cmask != 8'd0 || edge_en)) |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));

  assert_no_repeat_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && edge_en && fire && !ctrl_wr) |=> !fire);

  assert_unknown_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cnt_wr && !code_ok) |=> $stable(cnt));
endmodule

bind perf_evt_counter pec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_wr (ctrl_wr),
  .cnt_wr  (cnt_wr),
  .wdata   (reg_wdata_i),
  .cnt     (cnt),
  .en      (ctrl_q.en),
  .edge_en (ctrl_q.edge_en),
  .cmask   (ctrl_q.cmask),
  .code    (ctrl_q.code),
  .fire    (fire)
);

// File: tb/perf_evt_counter_test.sv
module perf_evt_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we, addr;
  logic [47:0] wdata, rdata;
  logic [4:0]  snoop;
  logic [1:0]  lk_vld;
  logic [3:0]  lk_state;
  logic [7:0]  lk_req;
  logic [5:0]  trk_pend, coh_pend;
  logic        trk_alloc, coh_alloc;
  logic [1:0]  trk_kind;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  perf_evt_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .snoop_resp_i(snoop),
    .lk_vld_i(lk_vld), .lk_state_i(lk_state), .lk_req_i(lk_req),
    .trk_pend_i(trk_pend), .coh_pend_i(coh_pend), .trk_alloc_i(trk_alloc),
    .trk_kind_i(trk_kind), .coh_alloc_i(coh_alloc)
  );

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [47:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [47:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle();
    snoop = '0; lk_vld = '0; lk_state = '0; lk_req = '0;
    trk_pend = '0; coh_pend = '0; trk_alloc = 1'b0; trk_kind = '0; coh_alloc = 1'b0;
  endtask

  function automatic logic [47:0] mk(input logic [7:0] code, input logic [7:0] um,
                                     input logic [7:0] cm, input logic ed,
                                     input logic iv, input logic en);
    return {21'd0, en, iv, ed, cm, um, code};
  endfunction

  task automatic cfg(input logic [47:0] c);
    idle();
    wr(1'b0, c);
    wr(1'b1, 48'd0);
  endtask

  task automatic t_reset();
    logic [47:0] v;
    rd(1'b1, v); check("R1 count", v, 48'd0);
    rd(1'b0, v); check("R1 ctrl", v, 48'd0);
    wr(1'b0, 48'hFFFF_F5A5_A5A5);
    rd(1'b0, v); check("R1 ctrl readback", v, 48'h0000_05A5_A5A5);
  endtask

  task automatic t_occupancy();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_pend = 6'd5; coh_pend = 6'd9; run(3); idle();
    rd(1'b1, v); check("R2 R10 tracker occupancy", v, 48'd15);
    cfg(mk(8'h83, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_pend = 6'd5; coh_pend = 6'd9; run(2); idle();
    rd(1'b1, v); check("R10 coherency occupancy", v, 48'd18);
  endtask

  task automatic t_snoop();
    logic [47:0] v;
    cfg(mk(8'h22, 8'h09, 8'd0, 1'b0, 1'b0, 1'b1));
    snoop = 5'b01011; run(2); idle();
    rd(1'b1, v); check("R8 snoop mask 0x09", v, 48'd4);
    cfg(mk(8'h22, 8'hE0, 8'd0, 1'b0, 1'b0, 1'b1));
    snoop = 5'b11111; run(2); idle();
    rd(1'b1, v); check("R8 snoop upper bits", v, 48'd0);
  endtask

  task automatic t_lookup();
    logic [47:0] v;
    cfg(mk(8'h34, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    lk_vld = 2'b11; lk_state = {2'd3, 2'd0}; lk_req = {4'b0010, 4'b0001}; run(1); idle();
    rd(1'b1, v); check("R9 state M only", v, 48'd1);
    cfg(mk(8'h34, 8'h11, 8'd0, 1'b0, 1'b0, 1'b1));
    lk_vld = 2'b11; lk_state = {2'd0, 2'd0}; lk_req = {4'b0010, 4'b0001}; run(1); idle();
    rd(1'b1, v); check("R9 M with read filter", v, 48'd1);
    cfg(mk(8'h34, 8'h10, 8'd0, 1'b0, 1'b0, 1'b1));
    lk_vld = 2'b11; lk_state = {2'd0, 2'd1}; lk_req = {4'b0001, 4'b0001}; run(2); idle();
    rd(1'b1, v); check("R9 filter without state", v, 48'd0);
    cfg(mk(8'h34, 8'h06, 8'd0, 1'b0, 1'b0, 1'b1));
    lk_vld = 2'b11; lk_state = {2'd2, 2'd1}; lk_req = {4'b1000, 4'b0100}; run(1);
    lk_vld = 2'b01; run(1); idle();
    rd(1'b1, v); check("R9 E/S lanes", v, 48'd3);
  endtask

  task automatic t_request();
    logic [47:0] v;
    cfg(mk(8'h81, 8'h20, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_alloc = 1'b1;
    trk_kind = 2'd0; run(1); trk_kind = 2'd1; run(1); trk_kind = 2'd2; run(1); idle();
    rd(1'b1, v); check("R11 writes", v, 48'd2);
    cfg(mk(8'h81, 8'h80, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_alloc = 1'b1;
    trk_kind = 2'd0; run(1); trk_kind = 2'd1; run(1); trk_kind = 2'd2; run(1); idle();
    rd(1'b1, v); check("R11 evictions", v, 48'd1);
    cfg(mk(8'h81, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_alloc = 1'b1;
    trk_kind = 2'd0; run(1); trk_kind = 2'd1; run(1); trk_kind = 2'd2; run(1); idle();
    rd(1'b1, v); check("R11 all kinds", v, 48'd3);
    cfg(mk(8'h84, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    coh_alloc = 1'b1; trk_alloc = 1'b1; run(2); idle();
    rd(1'b1, v); check("R11 coherency allocs", v, 48'd2);
  endtask

  task automatic t_threshold();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd4, 1'b0, 1'b0, 1'b1));
    trk_pend = 6'd3; run(1); trk_pend = 6'd4; run(1);
    trk_pend = 6'd7; run(1); trk_pend = 6'd0; run(1);
    rd(1'b1, v); check("R3 threshold ge", v, 48'd2);
    cfg(mk(8'h80, 8'h01, 8'd4, 1'b0, 1'b1, 1'b1));
    trk_pend = 6'd3; run(1); trk_pend = 6'd4; run(1);
    trk_pend = 6'd7; run(1); trk_pend = 6'd0; run(1);
    rd(1'b1, v); check("R4 inverted lt", v, 48'd2);
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b0, 1'b1, 1'b1));
    trk_pend = 6'd3; run(2); idle();
    rd(1'b1, v); check("R4 invert ignored without threshold", v, 48'd6);
  endtask

  task automatic t_edge();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd4, 1'b1, 1'b0, 1'b1));
    trk_pend = 6'd5; run(3); trk_pend = 6'd0; run(1);
    trk_pend = 6'd6; run(2); idle();
    rd(1'b1, v); check("R5 edge with threshold", v, 48'd2);
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b1, 1'b0, 1'b1));
    trk_pend = 6'd2; run(2); trk_pend = 6'd0; run(1);
    trk_pend = 6'd3; run(1); idle();
    rd(1'b1, v); check("R5 edge on nonzero", v, 48'd2);
  endtask

  task automatic t_edge_clear();
    logic [47:0] v;
    logic [47:0] c;
    c = mk(8'h80, 8'h01, 8'd0, 1'b1, 1'b0, 1'b1);
    cfg(c);
    trk_pend = 6'd5; run(3);
    rd(1'b1, v); check("R14 held condition once", v, 48'd1);
    wr(1'b0, c);
    run(1);
    rd(1'b1, v); check("R14 recount after control write", v, 48'd2);
    idle();
  endtask

  task automatic t_preload();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    wr(1'b1, 48'h1234);
    rd(1'b1, v); check("R6 preload readback", v, 48'h1234);
    trk_pend = 6'd3;
    wr(1'b1, 48'd100);
    rd(1'b1, v); check("R6 write beats increment", v, 48'd100);
    run(1); idle();
    rd(1'b1, v); check("R6 count after preload", v, 48'd103);
  endtask

  task automatic t_enable();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b0, 1'b0, 1'b0));
    wr(1'b1, 48'd55);
    trk_pend = 6'd5; run(3); idle();
    rd(1'b1, v); check("R7 disabled holds", v, 48'd55);
  endtask

  task automatic t_wrap();
    logic [47:0] v;
    cfg(mk(8'h80, 8'h01, 8'd0, 1'b0, 1'b0, 1'b1));
    wr(1'b1, 48'hFFFF_FFFF_FFFE);
    trk_pend = 6'd3; run(1); idle();
    rd(1'b1, v); check("R13 wrap", v, 48'd1);
  endtask

  task automatic t_unknown();
    logic [47:0] v;
    cfg(mk(8'h55, 8'hFF, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_pend = 6'd7; snoop = 5'b11111; trk_alloc = 1'b1; run(2); idle();
    rd(1'b1, v); check("R12 unknown code", v, 48'd0);
    cfg(mk(8'h80, 8'h02, 8'd0, 1'b0, 1'b0, 1'b1));
    trk_pend = 6'd7; run(2); idle();
    rd(1'b1, v); check("R12 unmatched mask", v, 48'd0);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = 1'b0; wdata = '0;
    idle();
    run(3);
    rst_n = 1'b1;
    run(1);
    t_reset();
    t_occupancy();
    t_snoop();
    t_lookup();
    t_request();
    t_threshold();
    t_edge();
    t_edge_clear();
    t_preload();
    t_enable();
    t_wrap();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule